// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is one comparator channel of a multi-channel event timer. It watches a free-running 64-bit main counter supplied from outside and emits a one-cycle fire pulse when the counter reaches the channel's comparator value. It can fire once (one-shot), or re-arm itself after every match by adding a stored period (periodic). A 32-bit mode restricts the comparison to the low half of the counter. In 32-bit one-shot mode it can also produce an extra event when the low counter half wraps.

Software reaches the channel through write strobes for the configuration and comparator registers. Each strobe carries one 32-bit half. Both registers are visible on read-back outputs. In periodic mode a comparator write goes to a hidden period register, and it only loads the comparator itself while a self-clearing set-value bit is armed. A register write in the same clock as a match takes precedence over the periodic advance. The fire pulse is still emitted in that case. At most one write strobe is active per clock.

Top module: `evt_cmp_channel`

## Requirements
- R1: After reset the comparator reads all ones, the configuration reads zero, the hidden period is zero, no wrap event is pending, and fire_o is low.
- R2: In one-shot mode a comparator write loads the addressed 32-bit half directly. fire_o pulses high for one cycle in the clock after an edge at which the counter equals the comparator, and the comparator does not change on its own.
- R3: In periodic mode with a non-zero period, each match adds the period to the comparator. In 32-bit mode the new value is truncated to its low 32 bits, with the upper half read as zero.
- R4: In 32-bit mode a match needs only the low 32 counter bits to equal the low 32 comparator bits. The upper counter half is not compared.
- R5: In periodic mode a comparator write always updates the period. It changes the comparator only when the set-value bit (configuration bit 3) is 1.
- R6: Any accepted comparator write clears the set-value bit.
- R7: With 32-bit mode on, writes to the comparator's upper half have no effect, and lower-half writes zero the upper half. Switching 32-bit mode on truncates the stored comparator and period to 32 bits.
- R8: A periodic channel whose period is zero fires once at its match and leaves the comparator unchanged.
- R9: No fire pulse is produced for a match when run_i is low, or when the channel enable (configuration bit 0) is 0.
- R10: In 32-bit one-shot mode, when the channel is armed (by a register write or by run_i rising) while the target's low half is non-zero and below the counter's low half, it fires once when the low counter half reaches zero, and again at the real match. Otherwise only the match fires.
- R11: Configuration layout: bit 0 channel enable, bit 1 periodic, bit 2 32-bit mode, bit 3 set-value. All other bits read zero, and a write to the upper configuration half changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_i | input | 1 | Global enable; matches are evaluated only while high |
| count_i | input | 64 | Main counter value |
| cfg_wr_lo_i | input | 1 | Write strobe, configuration lower half |
| cfg_wr_hi_i | input | 1 | Write strobe, configuration upper half (re-arms only) |
| cmp_wr_lo_i | input | 1 | Write strobe, comparator lower half |
| cmp_wr_hi_i | input | 1 | Write strobe, comparator upper half |
| wdata_i | input | 32 | Write data for the addressed half |
| fire_o | output | 1 | One-cycle fire event |
| cfg_o | output | 64 | Configuration read-back |
| cmp_o | output | 64 | Comparator read-back |

## Verification
A wrong comparator or mode bit becomes visible on cmp_o or cfg_o in the clock after the write or match that caused it. The reference model compares both every cycle. A wrong hidden period or wrap flag stays invisible until the next periodic advance or low-half wrap. The scenarios therefore run the counter through those points and check the advanced comparator value and the exact number of fire pulses. A missing or extra fire pulse is caught in the cycle it appears.

// File: rtl/evt_pkg.sv
// Shared definitions for the event timer comparator channel.
// Assumes configuration fields are packed at the bit positions below.
package evt_pkg;
    localparam int CFG_EN   = 0;
    localparam int CFG_PER  = 1;
    localparam int CFG_W32  = 2;
    localparam int CFG_SETV = 3;
    localparam int CFG_BITS = 4;

    typedef struct packed {
        logic setv;
        logic w32;
        logic per;
        logic en;
    } chan_cfg_t;
endpackage

// File: rtl/evt_cmp_match.sv
// Equality detector: counter vs comparator, full width or low half.
// Also flags the low-half wrap point while a wrap event is pending.
// Assumes the counter advances by at most one per clock while run_i is high.
module evt_cmp_match #(
    parameter int CNT_W = 64
) (
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             w32_i,
    input  logic             run_i,
    input  logic             wrap_pend_i,
    output logic             hit_o,
    output logic             wrap_hit_o
);
    localparam int HALF = CNT_W / 2;

    logic lo_eq;
    logic hi_eq;

    // Split the compare so 32-bit mode ignores the upper half.
    assign lo_eq = (count_i[HALF-1:0] == cmp_i[HALF-1:0]);
    assign hi_eq = (count_i[CNT_W-1:HALF] == cmp_i[CNT_W-1:HALF]);

    assign hit_o      = run_i && lo_eq && (w32_i || hi_eq);
    assign wrap_hit_o = run_i && wrap_pend_i && (count_i[HALF-1:0] == '0);
endmodule

// File: rtl/evt_cmp_regs.sv
// Configuration, comparator and hidden period storage with half-word
// writes, set-value handling and periodic advance.
// Assumes at most one write strobe per clock; writes beat the advance.
module evt_cmp_regs
    import evt_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr_lo_i,
    input  logic               cfg_wr_hi_i,
    input  logic               cmp_wr_lo_i,
    input  logic               cmp_wr_hi_i,
    input  logic [CNT_W/2-1:0] wdata_i,
    input  logic               hit_i,
    output chan_cfg_t          cfg_o,
    output logic [CNT_W-1:0]   cmp_o,
    output logic               wr_arm_o,
    output logic               nxt_w32_o,
    output logic               nxt_per_o,
    output logic [CNT_W/2-1:0] nxt_cmp_lo_o
);
    localparam int HALF = CNT_W / 2;

    chan_cfg_t        cfg_q, cfg_d;
    logic [CNT_W-1:0] cmp_q, cmp_d, per_q, per_d;
    logic [CNT_W-1:0] cmp_wv, per_wv, sum, adv;
    logic             take;

    // A comparator write is accepted unless it targets the upper half in 32-bit mode.
    assign take = cmp_wr_lo_i || (cmp_wr_hi_i && !cfg_q.w32);

    // Merge write data into the addressed half of comparator and period.
    assign cmp_wv = cfg_q.w32   ? {{HALF{1'b0}}, wdata_i} :
                    cmp_wr_hi_i ? {wdata_i, cmp_q[HALF-1:0]} :
                                  {cmp_q[CNT_W-1:HALF], wdata_i};
    assign per_wv = cfg_q.w32   ? {{HALF{1'b0}}, wdata_i} :
                    cmp_wr_hi_i ? {wdata_i, per_q[HALF-1:0]} :
                                  {per_q[CNT_W-1:HALF], wdata_i};

    // Periodic advance, truncated in 32-bit mode.
    assign sum = cmp_q + per_q;
    assign adv = cfg_q.w32 ? {{HALF{1'b0}}, sum[HALF-1:0]} : sum;

    // Next-state selection: configuration write, comparator write, then advance.
    always_comb begin
        cfg_d = cfg_q;
        cmp_d = cmp_q;
        per_d = per_q;
        if (cfg_wr_lo_i) begin
            cfg_d = chan_cfg_t'(wdata_i[CFG_BITS-1:0]);
            if (cfg_d.w32) begin
                cmp_d = {{HALF{1'b0}}, cmp_q[HALF-1:0]};
                per_d = {{HALF{1'b0}}, per_q[HALF-1:0]};
            end
        end else if (take) begin
            if (!cfg_q.per || cfg_q.setv) cmp_d = cmp_wv;
            if (cfg_q.per) per_d = per_wv;
            cfg_d.setv = 1'b0;
        end else if (hit_i && cfg_q.per && (per_q != '0)) begin
            cmp_d = adv;
        end
    end

    // State registers with reset values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            cmp_q <= '1;
            per_q <= '0;
        end else begin
            cfg_q <= cfg_d;
            cmp_q <= cmp_d;
            per_q <= per_d;
        end
    end

    assign cfg_o        = cfg_q;
    assign cmp_o        = cmp_q;
    assign wr_arm_o     = cfg_wr_lo_i || cfg_wr_hi_i || take;
    assign nxt_w32_o    = cfg_d.w32;
    assign nxt_per_o    = cfg_d.per;
    assign nxt_cmp_lo_o = cmp_d[HALF-1:0];
endmodule

// File: rtl/evt_cmp_wrap.sv
// Pending-wrap tracker for 32-bit one-shot mode. Re-evaluated whenever
// the channel is armed (register write or run rising); cleared when the
// wrap event is taken.
// Assumes arming uses the counter value presented in the arming clock.
module evt_cmp_wrap #(
    parameter int HALF = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_i,
    input  logic            wr_arm_i,
    input  logic            nxt_w32_i,
    input  logic            nxt_per_i,
    input  logic [HALF-1:0] nxt_cmp_lo_i,
    input  logic [HALF-1:0] count_lo_i,
    input  logic            wrap_hit_i,
    output logic            wrap_pend_o
);
    logic run_q;
    logic arm;
    logic beyond;

    // Target lies past the next low-half wrap.
    assign beyond = nxt_w32_i && !nxt_per_i && (nxt_cmp_lo_i != '0) &&
                    (nxt_cmp_lo_i < count_lo_i);
    assign arm    = wr_arm_i || (run_i && !run_q);

    // Track run edge and the pending wrap flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q       <= 1'b0;
            wrap_pend_o <= 1'b0;
        end else begin
            run_q <= run_i;
            if (arm)             wrap_pend_o <= beyond;
            else if (wrap_hit_i) wrap_pend_o <= 1'b0;
        end
    end
endmodule

// File: rtl/evt_cmp_channel.sv
// Top of one event timer comparator channel: storage, matcher, wrap
// tracker and the registered fire pulse.
// Assumes the counter is supplied externally and steps by at most one.
module evt_cmp_channel
    import evt_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic [CNT_W-1:0]   count_i,
    input  logic               cfg_wr_lo_i,
    input  logic               cfg_wr_hi_i,
    input  logic               cmp_wr_lo_i,
    input  logic               cmp_wr_hi_i,
    input  logic [CNT_W/2-1:0] wdata_i,
    output logic               fire_o,
    output logic [CNT_W-1:0]   cfg_o,
    output logic [CNT_W-1:0]   cmp_o
);
    localparam int HALF = CNT_W / 2;

    chan_cfg_t        cfg_q;
    logic [CNT_W-1:0] cmp_q;
    logic             hit, wrap_hit, wrap_pend, wr_arm, nxt_w32, nxt_per;
    logic [HALF-1:0]  nxt_cmp_lo;
    logic             fire_q;

    evt_cmp_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_lo_i(cfg_wr_lo_i), .cfg_wr_hi_i(cfg_wr_hi_i),
        .cmp_wr_lo_i(cmp_wr_lo_i), .cmp_wr_hi_i(cmp_wr_hi_i),
        .wdata_i(wdata_i), .hit_i(hit),
        .cfg_o(cfg_q), .cmp_o(cmp_q), .wr_arm_o(wr_arm),
        .nxt_w32_o(nxt_w32), .nxt_per_o(nxt_per), .nxt_cmp_lo_o(nxt_cmp_lo)
    );

    evt_cmp_match #(.CNT_W(CNT_W)) u_match (
        .count_i(count_i), .cmp_i(cmp_q), .w32_i(cfg_q.w32),
        .run_i(run_i), .wrap_pend_i(wrap_pend),
        .hit_o(hit), .wrap_hit_o(wrap_hit)
    );

    evt_cmp_wrap #(.HALF(HALF)) u_wrap (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .wr_arm_i(wr_arm),
        .nxt_w32_i(nxt_w32), .nxt_per_i(nxt_per), .nxt_cmp_lo_i(nxt_cmp_lo),
        .count_lo_i(count_i[HALF-1:0]), .wrap_hit_i(wrap_hit),
        .wrap_pend_o(wrap_pend)
    );

    // Register the fire event, gated by the channel enable.
    always_ff @(posedge clk) begin
        if (!rst_n) fire_q <= 1'b0;
        else        fire_q <= cfg_q.en && (hit || wrap_hit);
    end

    assign fire_o = fire_q;
    assign cfg_o  = {{(CNT_W-CFG_BITS){1'b0}}, cfg_q};
    assign cmp_o  = cmp_q;
endmodule

// File: rtl/evt_cmp_channel_chk.sv
// Property checker for the comparator channel, bound to the top module.
// Assumes the single-strobe-per-clock usage stated in the brief.
module evt_cmp_channel_chk
    import evt_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_i,
    input logic             cfg_wr_lo_i,
    input logic             cmp_wr_lo_i,
    input logic             cmp_wr_hi_i,
    input logic             fire_o,
    input logic [CNT_W-1:0] cfg_o,
    input logic [CNT_W-1:0] cmp_o
);
    localparam int HALF = CNT_W / 2;

    p_halt_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !fire_o) else $error("fire while halted");

    p_chan_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_o[CFG_EN] |=> !fire_o) else $error("fire while channel off");

    p_setv_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_wr_lo_i && !cfg_wr_lo_i) |=> !cfg_o[CFG_SETV]) else $error("set-value kept");

    p_hi_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_o[CFG_W32] && !cfg_o[CFG_PER] && cmp_wr_hi_i && !cmp_wr_lo_i && !cfg_wr_lo_i)
        |=> $stable(cmp_o)) else $error("upper write taken in 32-bit mode");

    p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_o[CFG_W32] |-> (cmp_o[CNT_W-1:HALF] == '0)) else $error("upper comparator not zero");

    p_oneshot_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_o[CFG_PER] && !cmp_wr_lo_i && !cmp_wr_hi_i && !cfg_wr_lo_i)
        |=> $stable(cmp_o)) else $error("one-shot comparator moved");

    p_cfg_layout_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_o[CNT_W-1:CFG_BITS] == '0) else $error("reserved config bits set");
endmodule

bind evt_cmp_channel evt_cmp_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run_i(run_i),
    .cfg_wr_lo_i(cfg_wr_lo_i), .cmp_wr_lo_i(cmp_wr_lo_i), .cmp_wr_hi_i(cmp_wr_hi_i),
    .fire_o(fire_o), .cfg_o(cfg_o), .cmp_o(cmp_o)
);

// File: tb/tb_evt_cmp_channel.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared on every clock, plus
// directed checks on fire counts and register values.
module tb_evt_cmp_channel;
    localparam logic [63:0] LO_MASK = 64'h0000_0000_FFFF_FFFF;

    logic        clk = 1'b0, rst_n = 1'b0, run = 1'b0;
    logic [63:0] cnt = '0;
    logic        cfg_wr_lo = 0, cfg_wr_hi = 0, cmp_wr_lo = 0, cmp_wr_hi = 0;
    logic [31:0] wdata = '0;
    logic        fire;
    logic [63:0] cfg_out, cmp_out;

    int    checks = 0, fails = 0, nfire = 0;
    string cur_req = "R1";
    bit    inc = 0, done = 0;

    // model state
    logic [3:0]  m_cfg;
    logic [63:0] m_cmp, m_per;
    bit          m_wrap, m_runq, m_fire;

    always #4 clk = ~clk;

    evt_cmp_channel dut (
        .clk(clk), .rst_n(rst_n), .run_i(run), .count_i(cnt),
        .cfg_wr_lo_i(cfg_wr_lo), .cfg_wr_hi_i(cfg_wr_hi),
        .cmp_wr_lo_i(cmp_wr_lo), .cmp_wr_hi_i(cmp_wr_hi),
        .wdata_i(wdata), .fire_o(fire), .cfg_o(cfg_out), .cmp_o(cmp_out)
    );

    always @(negedge clk) if (inc) cnt = cnt + 64'd1;

    task automatic model_step();
        logic [63:0] ncmp, nper, wv_c, wv_p, sum;
        logic [3:0]  ncfg;
        bit hit, wev, take, arm, w32;
        if (!rst_n) begin
            m_cfg = '0; m_cmp = '1; m_per = '0;
            m_wrap = 0; m_runq = 0; m_fire = 0;
            return;
        end
        w32  = m_cfg[2];
        hit  = run && (w32 ? (cnt[31:0] == m_cmp[31:0]) : (cnt == m_cmp));
        wev  = run && m_wrap && (cnt[31:0] == 32'h0);
        ncfg = m_cfg; ncmp = m_cmp; nper = m_per;
        take = cmp_wr_lo || (cmp_wr_hi && !w32);
        if (cfg_wr_lo) begin
            ncfg = wdata[3:0];
            if (ncfg[2]) begin ncmp = m_cmp & LO_MASK; nper = m_per & LO_MASK; end
        end else if (take) begin
            if (w32) begin wv_c = {32'h0, wdata}; wv_p = wv_c; end
            else if (cmp_wr_lo) begin wv_c = {m_cmp[63:32], wdata}; wv_p = {m_per[63:32], wdata}; end
            else begin wv_c = {wdata, m_cmp[31:0]}; wv_p = {wdata, m_per[31:0]}; end
            if (!m_cfg[1] || m_cfg[3]) ncmp = wv_c;
            if (m_cfg[1]) nper = wv_p;
            ncfg[3] = 1'b0;
        end else if (hit && m_cfg[1] && m_per != 0) begin
            sum  = m_cmp + m_per;
            ncmp = w32 ? (sum & LO_MASK) : sum;
        end
        arm = cfg_wr_lo || cfg_wr_hi || take || (run && !m_runq);
        if (arm) m_wrap = ncfg[2] && !ncfg[1] && ncmp[31:0] != 0 && ncmp[31:0] < cnt[31:0];
        else if (wev) m_wrap = 0;
        m_fire = m_cfg[0] && (hit || wev);
        m_runq = run; m_cfg = ncfg; m_cmp = ncmp; m_per = nper;
    endtask

    // Per-clock comparison against the model.
    always @(posedge clk) begin
        model_step();
        #2;
        checks++;
        if (fire !== m_fire || cmp_out !== m_cmp || cfg_out !== {60'h0, m_cfg}) begin
            fails++;
            $display("FAIL %s model: fire %b cmp %h cfg %h expected fire %b cmp %h cfg %h",
                     cur_req, fire, cmp_out, cfg_out, m_fire, m_cmp, {60'h0, m_cfg});
        end
        if (fire === 1'b1) nfire++;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int which, input logic [31:0] d);
        @(negedge clk);
        wdata = d;
        case (which)
            0: cfg_wr_lo = 1;
            1: cfg_wr_hi = 1;
            2: cmp_wr_lo = 1;
            default: cmp_wr_hi = 1;
        endcase
        @(negedge clk);
        cfg_wr_lo = 0; cfg_wr_hi = 0; cmp_wr_lo = 0; cmp_wr_hi = 0;
    endtask

    task automatic load(input logic [63:0] v);
        @(negedge clk);
        cnt = v;
    endtask

    task automatic go(input int n, input bit r);
        nfire = 0;
        @(negedge clk);
        run = r; inc = 1;
        repeat (n) @(negedge clk);
        run = 0; inc = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        cur_req = "R1";
        chk("R1 cmp reset", cmp_out, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R1 cfg reset", cfg_out, 64'h0);
        chk("R1 fire reset", {63'h0, fire}, 64'h0);

        cur_req = "R11";
        wr(0, 32'hFFFF_FFF0);
        chk("R11 reserved bits", cfg_out, 64'h0);
        wr(0, 32'h1);
        wr(1, 32'hFFFF_FFFF);
        chk("R11 upper half write", cfg_out, 64'h1);

        cur_req = "R2";
        wr(2, 32'd100);
        wr(3, 32'd0);
        chk("R2 direct load", cmp_out, 64'd100);
        load(64'd90);
        go(30, 1);
        chk("R2 one fire", nfire, 1);
        chk("R2 cmp held", cmp_out, 64'd100);

        cur_req = "R9";
        wr(0, 32'h0);
        wr(2, 32'd200);
        load(64'd190);
        go(30, 1);
        chk("R9 channel off", nfire, 0);
        wr(0, 32'h1);
        load(64'd190);
        go(30, 0);
        chk("R9 halted", nfire, 0);

        cur_req = "R5";
        wr(0, 32'hB);
        wr(2, 32'd300);
        chk("R6 set-value cleared", cfg_out, 64'h3);
        chk("R5 set-value load", cmp_out, 64'd300);
        wr(2, 32'd20);
        chk("R5 period-only write", cmp_out, 64'd300);
        cur_req = "R3";
        load(64'd295);
        go(70, 1);
        chk("R3 periodic fires", nfire, 4);
        chk("R3 advanced cmp", cmp_out, 64'd380);

        cur_req = "R8";
        wr(0, 32'hB);
        wr(2, 32'd500);
        wr(2, 32'd0);
        load(64'd495);
        go(30, 1);
        chk("R8 single fire", nfire, 1);
        chk("R8 cmp unchanged", cmp_out, 64'd500);

        cur_req = "R7";
        wr(0, 32'h1);
        wr(3, 32'h12);
        wr(2, 32'h40);
        chk("R2 half writes", cmp_out, 64'h12_0000_0040);
        wr(0, 32'h5);
        chk("R7 truncate on entry", cmp_out, 64'h40);
        wr(3, 32'h77);
        chk("R7 upper write ignored", cmp_out, 64'h40);

        cur_req = "R4";
        load(64'h5_0000_0030);
        go(30, 1);
        chk("R4 low-half match", nfire, 1);

        cur_req = "R10";
        load(64'h1_FFFF_FFF0);
        wr(2, 32'h10);
        go(40, 1);
        chk("R10 wrap plus match", nfire, 2);
        load(64'h2_0000_0020);
        wr(2, 32'h30);
        go(40, 1);
        chk("R10 no wrap event", nfire, 1);

        cur_req = "R3";
        wr(0, 32'hF);
        wr(2, 32'hFFFF_FFF0);
        wr(2, 32'h20);
        load(64'h3_FFFF_FFE8);
        go(48, 1);
        chk("R3 32-bit periodic fires", nfire, 2);
        chk("R3 truncated advance", cmp_out, 64'h30);

        done = 1;
        summary();
        $finish;
    end
endmodule